// File: doc/BRIEF.md
# UDB Stripping Cell Formatter

This block sits between a cell buffer and the payload mapper of a transmit path. It accepts one cell at a time and turns it into a plain 53-byte ATM cell stream, one byte per clock, with a byte-valid and a start-of-cell marker. The input side is 16 bits wide with a valid/ready handshake. In wide mode every word carries two bytes, and the byte in bits 15:8 leaves first. In narrow mode only the low byte of each word counts.

A wide cell is 27 words, because it carries one extra user-defined byte (UDB) beyond the 53 that leave the block. Two wide layouts exist. In the first, the third word holds both UDBs side by side. In the second, the first UDB shares the third word with payload byte 1, and the spare UDB closes the cell after payload byte 48. In either layout the spare UDB is removed. A narrow cell is already 53 bytes (four header bytes, one UDB, 48 payload bytes) and passes through unchanged.

A cell starts at a word flagged with a start marker. The layout and width selected at that word hold for the whole cell. Words that arrive between cells without the marker are thrown away.

Top module: `udb_strip_formatter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` and `out_soc` are 0 and `in_ready` is 1.
- R2: With `wide_mode`=1, a cell is 27 accepted words and 53 output bytes, and bits 15:8 of each word leave before bits 7:0.
- R3: With `fmt_sel`=0 (layout 1, the reset default of the control bit), the low byte of word index 2 (counting from 0) is the spare UDB and is dropped, while its high byte is kept as output byte 4.
- R4: With `fmt_sel`=1 (layout 2), the low byte of word index 26 is the spare UDB and is dropped, and every other byte of the cell is kept.
- R5: With `wide_mode`=0, a cell is 53 accepted words, output byte i equals bits 7:0 of word i, and bits 15:8 have no effect.
- R6: `out_soc` is 1 exactly with the first output byte of each cell and only when `out_valid` is 1, and each cell produces exactly 53 valid bytes.
- R7: A word accepted outside a cell starts a cell only if `in_sof`=1; otherwise it is discarded and produces no output. `in_sof` on a word inside a cell is ignored.
- R8: `wide_mode` and `fmt_sel` are sampled with the start word of a cell, and changing them during the cell has no effect on that cell.
- R9: In wide mode, after a word with two kept bytes is accepted, `in_ready` is 0 in the next cycle. With words offered on every cycle, the 53 bytes of a cell leave on consecutive cycles.
- R10: When `out_valid` is 0 and no word was accepted at the previous edge, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: 16-bit words, two bytes each; 0: 8-bit, low byte only |
| fmt_sel | input | 1 | Wide layout: 0 = UDB pair in word 2, 1 = spare UDB last |
| in_data | input | 16 | Input word |
| in_valid | input | 1 | Input word offered |
| in_sof | input | 1 | Marks the first word of a cell |
| in_ready | output | 1 | Block can take a word this cycle |
| out_byte | output | 8 | Output cell byte |
| out_valid | output | 1 | out_byte is valid |
| out_soc | output | 1 | out_byte is header byte 1 of a cell |

## Verification
In one cycle the block can both emit the last kept byte of one word and load the next word, or both drain the final byte of a cell and take the start word of the next cell. The bench provokes this by offering words on every cycle across back-to-back cells, in both layouts and in narrow mode. It judges the result by comparing every output byte and its start flag against a stream built arithmetically from the layout, and by counting gaps inside each cell. It also sets a start marker in the middle of a cell, flips the width and layout after the start word, and inserts unmarked junk words between cells, so that the cell-tracking decision and the serialization meet in those same cycles.

// File: rtl/udb_fmt_pkg.sv
// Shared types for the UDB stripping formatter.
// Assumes bytes are 8 bits and input words hold exactly two bytes.
package udb_fmt_pkg;

    // Wide-mode layout choice; the zero value is the reset default.
    typedef enum logic {
        FMT_UDB_PAIR  = 1'b0,   // both UDBs share the third word
        FMT_UDB_SPLIT = 1'b1    // spare UDB closes the cell
    } udb_fmt_e;

    // Load request from the cell tracker to the byte holder.
    typedef struct packed {
        logic [1:0] cnt;   // kept bytes in this word: 0, 1 or 2
        logic [7:0] b0;    // first byte to emit
        logic [7:0] b1;    // second byte (valid when cnt == 2)
        logic       soc;   // b0 is header byte 1 of a cell
    } ld_req_t;

endpackage

// File: rtl/udb_cell_tracker.sv
// Cell tracker: follows the word position inside a cell, latches width and
// layout at the start word, and decides which bytes of each accepted word
// are kept. Assumes CELL_BYTES is odd, so a wide cell is (CELL_BYTES+1)/2
// words including one spare UDB.
module udb_cell_tracker
    import udb_fmt_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          fmt_sel,
    input  logic [15:0]   in_data,
    input  logic          in_sof,
    input  logic          accept,
    output ld_req_t       ld
);
    localparam int WORDS_WIDE   = (CELL_BYTES + 1) / 2;
    localparam int WORDS_NARROW = CELL_BYTES;
    localparam int IW           = $clog2(WORDS_NARROW);
    localparam logic [IW-1:0] LAST_WIDE   = IW'(WORDS_WIDE - 1);
    localparam logic [IW-1:0] LAST_NARROW = IW'(WORDS_NARROW - 1);
    localparam logic [IW-1:0] DROP_PAIR   = IW'(HDR_BYTES / 2);
    localparam logic [IW-1:0] DROP_SPLIT  = IW'(WORDS_WIDE - 1);

    logic           in_cell_q;
    logic [IW-1:0]  idx_q;
    logic           wide_q;
    udb_fmt_e       fmt_q;

    logic           cur_wide;
    udb_fmt_e       cur_fmt;
    logic [IW-1:0]  cur_idx;
    logic [IW-1:0]  last_idx;
    logic           take;
    logic           drop_lo;

    // Select live config for a start word, latched config inside a cell.
    always_comb begin
        cur_wide = in_cell_q ? wide_q : wide_mode;
        cur_fmt  = in_cell_q ? fmt_q  : udb_fmt_e'(fmt_sel);
        cur_idx  = in_cell_q ? idx_q  : '0;
        last_idx = cur_wide ? LAST_WIDE : LAST_NARROW;
        take     = in_cell_q | in_sof;
        drop_lo  = cur_wide &&
                   ((cur_fmt == FMT_UDB_PAIR  && cur_idx == DROP_PAIR) ||
                    (cur_fmt == FMT_UDB_SPLIT && cur_idx == DROP_SPLIT));
    end

    // Build the load request for the byte holder.
    always_comb begin
        ld.b0  = cur_wide ? in_data[15:8] : in_data[7:0];
        ld.b1  = in_data[7:0];
        ld.soc = !in_cell_q;
        if (!(accept && take))
            ld.cnt = 2'd0;
        else if (!cur_wide || drop_lo)
            ld.cnt = 2'd1;
        else
            ld.cnt = 2'd2;
    end

    // Advance the word position and latch the config at the start word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cell_q <= 1'b0;
            idx_q     <= '0;
            wide_q    <= 1'b0;
            fmt_q     <= FMT_UDB_PAIR;
        end else if (accept && take) begin
            if (!in_cell_q) begin
                wide_q <= wide_mode;
                fmt_q  <= udb_fmt_e'(fmt_sel);
            end
            if (cur_idx == last_idx) begin
                in_cell_q <= 1'b0;
                idx_q     <= '0;
            end else begin
                in_cell_q <= 1'b1;
                idx_q     <= cur_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/udb_byte_hold.sv
// Byte holder and serializer: keeps up to two bytes of one word and emits
// one byte per cycle through registered outputs. Assumes a load arrives only
// while ready is high, that is, when the holder empties at the same edge.
module udb_byte_hold
    import udb_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ld_req_t     ld,
    output logic        ready,
    output logic [7:0]  out_byte,
    output logic        out_valid,
    output logic        out_soc
);
    logic [1:0] cnt_q;
    logic [7:0] b0_q;
    logic [7:0] b1_q;
    logic       soc_q;

    // Ready when at most one byte is held, since it leaves at this edge.
    assign ready = (cnt_q <= 2'd1);

    // Shift one byte out per cycle and reload from the tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= 2'd0;
            b0_q      <= '0;
            b1_q      <= '0;
            soc_q     <= 1'b0;
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
        end else begin
            out_valid <= (cnt_q != 2'd0);
            out_soc   <= (cnt_q != 2'd0) && soc_q;
            if (cnt_q != 2'd0) begin
                out_byte <= b0_q;
                b0_q     <= b1_q;
                cnt_q    <= cnt_q - 2'd1;
                soc_q    <= 1'b0;
            end
            if (ld.cnt != 2'd0) begin
                b0_q  <= ld.b0;
                b1_q  <= ld.b1;
                cnt_q <= ld.cnt;
                soc_q <= ld.soc;
            end
        end
    end

endmodule

// File: rtl/udb_strip_formatter.sv
// Top of the UDB stripping formatter: takes cells as 16-bit words (wide) or
// low bytes (narrow), removes the spare UDB of wide cells and emits a
// CELL_BYTES-byte cell stream with a start-of-cell flag.
// Assumes the downstream side takes a byte on every cycle it is valid.
module udb_strip_formatter
    import udb_fmt_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide_mode,
    input  logic        fmt_sel,
    input  logic [15:0] in_data,
    input  logic        in_valid,
    input  logic        in_sof,
    output logic        in_ready,
    output logic [7:0]  out_byte,
    output logic        out_valid,
    output logic        out_soc
);
    ld_req_t    ld_req;
    logic       accept;
    logic [1:0] ld_cnt;

    assign accept = in_valid & in_ready;
    assign ld_cnt = ld_req.cnt;

    udb_cell_tracker #(
        .CELL_BYTES (CELL_BYTES),
        .HDR_BYTES  (HDR_BYTES)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .fmt_sel   (fmt_sel),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .accept    (accept),
        .ld        (ld_req)
    );

    udb_byte_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld_req),
        .ready     (in_ready),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .out_soc   (out_soc)
    );

endmodule

// File: rtl/udb_strip_formatter_chk.sv
// Property checker for udb_strip_formatter, attached with bind.
// Counts valid bytes since the last start-of-cell to check the cell length.
module udb_strip_formatter_chk #(
    parameter int CELL_BYTES = 53
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [1:0] ld_cnt,
    input logic       out_valid,
    input logic       out_soc
);
    localparam int CW = $clog2(CELL_BYTES + 1);
    localparam logic [CW-1:0] FULL = CW'(CELL_BYTES);

    logic [CW-1:0] seen_q;

    // Count the bytes of the cell currently leaving.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= '0;
        else if (out_valid)
            seen_q <= out_soc ? CW'(1) : seen_q + 1'b1;
    end

    // R6: start flag only with a valid byte
    p_soc_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    // R6: a new cell starts only after a full previous cell
    p_cell_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> (seen_q == '0 || seen_q == FULL));

    // R6: no cell runs past its length
    p_cell_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_soc) |-> (seen_q != '0 && seen_q < FULL));

    // R9: a two-byte load holds off the next word
    p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cnt == 2'd2) |=> !in_ready);

    // R10: an idle holder is ready
    p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !$past(in_valid && in_ready)) |-> in_ready);

endmodule

bind udb_strip_formatter udb_strip_formatter_chk #(
    .CELL_BYTES (CELL_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ld_cnt    (ld_cnt),
    .out_valid (out_valid),
    .out_soc   (out_soc)
);

// File: tb/sim_udb_strip_formatter.sv
module sim_udb_strip_formatter;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 53;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        fmt_sel = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_ready;
    logic [7:0]  out_byte;
    logic        out_valid;
    logic        out_soc;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 0;
    bit nogap = 0;

    logic [7:0] exp_b[$];
    bit         exp_s[$];
    string      exp_t[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    udb_strip_formatter u0 (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .fmt_sel(fmt_sel),
        .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof),
        .in_ready(in_ready), .out_byte(out_byte), .out_valid(out_valid),
        .out_soc(out_soc)
    );

    function automatic logic [7:0] gb(int c, int i);
        return 8'((c * 29 + i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] spare(int c);
        return 8'hC3 ^ 8'(c);
    endfunction

    // Input byte at slot i of a wide cell (54 slots, spare UDB included).
    function automatic logic [7:0] slot(int c, bit fmt, int i);
        if (!fmt) return (i < 5) ? gb(c, i) : (i == 5) ? spare(c) : gb(c, i - 1);
        return (i < NB) ? gb(c, i) : spare(c);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Output monitor: byte stream, start flag, cell length and gaps.
    int mcnt = 0;
    int mgaps = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (out_soc)
                    chk(mcnt == 0 || mcnt == NB, "R6", "bytes in previous cell", mcnt, NB);
                mcnt = out_soc ? 1 : mcnt + 1;
                if (exp_b.size() == 0) begin
                    chk(0, "R7", "unexpected output byte", out_byte, 0);
                end else begin
                    chk({out_soc, out_byte} == {exp_s[0], exp_b[0]}, exp_t[0],
                        "soc+byte", {out_soc, out_byte}, {exp_s[0], exp_b[0]});
                    void'(exp_b.pop_front());
                    void'(exp_s.pop_front());
                    void'(exp_t.pop_front());
                end
                if (mcnt == NB) begin
                    if (nogap) chk(mgaps == 0, "R9", "gaps inside cell", mgaps, 0);
                    mgaps = 0;
                end
            end else if (mcnt > 0 && mcnt < NB) begin
                mgaps++;
            end
        end
    end

    task automatic send_cell(int c, bit wide, bit fmt, int gap_every,
                             int mid_sof, bit flip, string tag);
        int nw;
        for (int i = 0; i < NB; i++) begin
            exp_b.push_back(gb(c, i));
            exp_s.push_back(i == 0);
            exp_t.push_back(tag);
        end
        nw = wide ? (NB + 1) / 2 : NB;
        for (int w = 0; w < nw; w++) begin
            @(negedge clk);
            if (gap_every > 0 && (w % gap_every) == 1) begin
                in_valid = 1'b0;
                repeat (2) @(negedge clk);
            end
            if (w == 0) begin
                wide_mode = wide;
                fmt_sel = fmt;
            end else if (w == 1 && flip) begin
                wide_mode = !wide;
                fmt_sel = !fmt;
            end
            in_valid = 1'b1;
            in_sof = (w == 0) || (w == mid_sof);
            if (wide) in_data = {slot(c, fmt, 2 * w), slot(c, fmt, 2 * w + 1)};
            else      in_data = {8'h5A ^ 8'(w * 13), gb(c, w)};
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        wide_mode = wide;
        fmt_sel = fmt;
    endtask

    // Unmarked words between cells: must be discarded (R7).
    task automatic send_junk(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof = 1'b0;
            in_data = 16'hBEEF ^ 16'(k);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain_check(string req);
        repeat (60) @(negedge clk);
        chk(exp_b.size() == 0, req, "bytes still expected", exp_b.size(), 0);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", "idle ready/valid",
            {in_ready, out_valid}, 2'b10);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({out_valid, out_soc, in_ready} == 3'b001, "R1", "in reset",
            {out_valid, out_soc, in_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk({out_valid, out_soc, in_ready} == 3'b001, "R1", "after reset",
            {out_valid, out_soc, in_ready}, 3'b001);

        // R2 R3: layout 1, back-to-back, gapless (R9)
        nogap = 1;
        for (int c = 0; c < 3; c++) send_cell(c, 1, 0, 0, -1, 0, "R2 R3");
        // R2 R4: layout 2, back-to-back
        for (int c = 3; c < 6; c++) send_cell(c, 1, 1, 0, -1, 0, "R2 R4");
        // alternate layouts cell by cell
        for (int c = 6; c < 10; c++) send_cell(c, 1, c[0], 0, -1, 0, "R3 R4");
        // R5: narrow cells, high byte noise
        for (int c = 10; c < 13; c++) send_cell(c, 0, c[0], 0, -1, 0, "R5");
        drain_check("R6");

        // R7: junk between cells, mid-cell start marker ignored
        nogap = 0;
        send_junk(5);
        send_cell(13, 1, 0, 0, 10, 0, "R7");
        send_junk(3);
        send_cell(14, 0, 0, 0, 20, 0, "R7");
        send_junk(2);
        drain_check("R7");

        // R8: width and layout flipped after the start word
        send_cell(15, 1, 0, 0, -1, 1, "R8");
        send_cell(16, 1, 1, 0, -1, 1, "R8");
        send_cell(17, 0, 1, 0, -1, 1, "R8");
        drain_check("R8");

        // Input gaps in both modes
        send_cell(18, 1, 1, 3, -1, 0, "R4");
        send_cell(19, 0, 0, 4, -1, 0, "R5");
        send_cell(20, 1, 0, 5, -1, 0, "R3");
        drain_check("R6");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule